// File: doc/BRIEF.md
# Packed SIMD Left Shift with Sticky Overflow Flag

This block takes a 32-bit word and shifts it left as a set of independent lanes. The lane split comes from a one-bit mode input. In paired-halfword mode the word is two 16-bit lanes. In quad-byte mode it is four 8-bit lanes. Every lane uses the same shift amount. Bits that leave the top of a lane are lost, and zeros fill from the bottom. The result is registered and appears on the cycle after the valid strobe.

Overflow is judged per lane, and the rule depends on the lane type:

- **Byte lanes** are treated as unsigned. Any set bit shifted out is an overflow.
- **Halfword lanes** are treated as signed. The bits shifted out and the new sign bit must all match the original sign, or the lane overflows.

An overflow in any lane sets a sticky flag at bit 22 of a 32-bit control register. The flag stays set until software clears it through the control-register write port or until reset.

Top module: `simd_shl_ovf`

## Requirements
- R1: With `mode`=1 (quad-byte), each 8-bit lane of `result` is that lane of `operand` shifted left by `shamt[2:0]`, keeping the low 8 bits (for example 0x87654321 by 3 gives 0x38281808).
- R2: In quad-byte mode a lane overflows when any of its top `shamt[2:0]` bits is 1 (0x87654321 by 3 overflows; 0x00000001 by 7 gives 0x00000080 with no overflow).
- R3: With `mode`=0 (paired-halfword), each 16-bit lane of `result` is that lane of `operand` shifted left by `shamt[3:0]`, keeping the low 16 bits (0x7FFF8000 by 1 gives 0xFFFE0000).
- R4: In paired-halfword mode a lane overflows unless its top `shamt`+1 bits are all equal (0x7FFF8000 by 1 overflows; 0x00000001 by 15 gives 0x00008000 and overflows; 0xFFC0FFFF by 4 gives 0xFC00FFF0 with no overflow).
- R5: A shift amount of zero in either mode returns the operand unchanged and never overflows.
- R6: In quad-byte mode, `shamt[3]` has no effect on the result or on the flag.
- R7: `result` and the flag update appear on the clock edge where `in_valid` is sampled high. While `in_valid` is low, both hold their values.
- R8: The overflow flag is `ctl_reg[22]` and is sticky: a later operation that does not overflow leaves it set. All other bits of `ctl_reg` read 0.
- R9: A write (`ctl_wr_en`=1) with `ctl_wr_data[22]`=0 clears the flag on the next edge. A write with `ctl_wr_data[22]`=1 neither sets nor clears it.
- R10: When an overflowing operation and a clearing write happen in the same cycle, the flag ends up set.
- R11: Synchronous active-high reset sets `result` and `ctl_reg` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts a shift this cycle |
| mode | input | 1 | 0 = two 16-bit lanes, 1 = four 8-bit lanes |
| operand | input | 32 | Packed source word |
| shamt | input | 4 | Shift amount; only bits [2:0] are used in quad-byte mode |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_wr_data | input | 32 | Write data; bit 22 = 0 clears the flag |
| result | output | 32 | Registered shifted word |
| ctl_reg | output | 32 | Control register; bit 22 is the sticky overflow flag |

## Verification
The bench targets the halfword cases where the signed rule differs from a plain "nonzero bits shifted out" test:

- A positive lane that turns negative, for example 0x0001 shifted by 15. A design using the unsigned rule would miss this overflow.
- A negative lane that stays negative, for example 0xFFC0 shifted by 4. The unsigned rule would wrongly report an overflow here.

In quad-byte mode the bench checks three further cases:

- A 7-bit shift into the top bit, which must not overflow. A design that uses the halfword rule in this mode would flag it.
- A shift field with bit 3 set. A design that fails to mask it would zero the result.
- A zero shift, which must return the operand unchanged and leave the flag alone.

The flag tests cover three behaviours:

- Stickiness across a clean operation.
- A write of 1 in bit 22, which must not set the flag.
- A clearing write in the same cycle as an overflow. A design that gives the write priority would lose the overflow.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int HALF_W   = 16;
  localparam int OVF_BIT  = 22;
  localparam int SHAMT_W  = $clog2(HALF_W);

  typedef enum logic {
    LANES_HALF = 1'b0,
    LANES_BYTE = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/shl_lane.sv
module shl_lane #(
  parameter int W          = 8,
  parameter int SW         = 3,
  parameter bit SIGNED_CHK = 1'b0
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] sh,
  output logic [W-1:0]  dout,
  output logic          ovf
);
  logic [SW:0]  rs;
  logic [W-1:0] spill;

  assign dout = din << sh;

  generate
    if (SIGNED_CHK) begin : g_signed
      // top sh+1 bits, sign-extended, must be uniform
      always_comb begin
        rs    = (SW+1)'(W - 1) - {1'b0, sh};
        spill = W'($signed(din) >>> rs);
        ovf   = !((spill == '0) || (spill == '1));
      end
    end else begin : g_unsigned
      // top sh bits must all be zero
      always_comb begin
        rs    = (SW+1)'(W) - {1'b0, sh};
        spill = din >> rs;
        ovf   = (sh != '0) && (spill != '0);
      end
    end
  endgenerate
endmodule

// File: rtl/simd_shl_core.sv
module simd_shl_core
  import simd_shl_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int BW     = BYTE_W,
  parameter int HW     = HALF_W
) (
  input  logic                  byte_mode,
  input  logic [DATA_W-1:0]     operand,
  input  logic [$clog2(HW)-1:0] shamt,
  output logic [DATA_W-1:0]     res,
  output logic                  ovf
);
  localparam int NB   = DATA_W / BW;
  localparam int NH   = DATA_W / HW;
  localparam int BSW  = $clog2(BW);
  localparam int HSW  = $clog2(HW);

  logic [DATA_W-1:0] res_b, res_h;
  logic [NB-1:0]     ovf_b;
  logic [NH-1:0]     ovf_h;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_byte
      shl_lane #(.W(BW), .SW(BSW), .SIGNED_CHK(1'b0)) lane_i (
        .din  (operand[i*BW +: BW]),
        .sh   (shamt[BSW-1:0]),
        .dout (res_b[i*BW +: BW]),
        .ovf  (ovf_b[i])
      );
    end
    for (genvar j = 0; j < NH; j++) begin : g_half
      shl_lane #(.W(HW), .SW(HSW), .SIGNED_CHK(1'b1)) lane_i (
        .din  (operand[j*HW +: HW]),
        .sh   (shamt),
        .dout (res_h[j*HW +: HW]),
        .ovf  (ovf_h[j])
      );
    end
  endgenerate

  assign res = byte_mode ? res_b : res_h;
  assign ovf = byte_mode ? (|ovf_b) : (|ovf_h);
endmodule

// File: rtl/ctl_flag_reg.sv
module ctl_flag_reg #(
  parameter int DATA_W = 32,
  parameter int FBIT   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              wr_en,
  input  logic              wr_keep,
  output logic [DATA_W-1:0] ctl_q
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (wr_en && !wr_keep) flag_d = 1'b0;
    if (set_i)             flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  always_comb begin
    ctl_q       = '0;
    ctl_q[FBIT] = flag_q;
  end
endmodule

// File: rtl/simd_shl_ovf.sv
module simd_shl_ovf
  import simd_shl_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int FBIT   = OVF_BIT,
  parameter int SHW    = SHAMT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode,
  input  logic [DATA_W-1:0] operand,
  input  logic [SHW-1:0]    shamt,
  input  logic              ctl_wr_en,
  input  logic [DATA_W-1:0] ctl_wr_data,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] ctl_reg
);
  lane_mode_e        lmode;
  logic [DATA_W-1:0] res_c;
  logic              ovf_c;
  logic              unused_wr_bits;

  assign lmode          = lane_mode_e'(mode);
  assign unused_wr_bits = ^{ctl_wr_data[DATA_W-1:FBIT+1], ctl_wr_data[FBIT-1:0]};

  simd_shl_core #(.DATA_W(DATA_W), .BW(BYTE_W), .HW(1 << SHW)) core_i (
    .byte_mode (lmode == LANES_BYTE),
    .operand   (operand),
    .shamt     (shamt),
    .res       (res_c),
    .ovf       (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst)           result <= '0;
    else if (in_valid) result <= res_c;
  end

  ctl_flag_reg #(.DATA_W(DATA_W), .FBIT(FBIT)) flag_i (
    .clk     (clk),
    .rst     (rst),
    .set_i   (in_valid && ovf_c),
    .wr_en   (ctl_wr_en),
    .wr_keep (ctl_wr_data[FBIT]),
    .ctl_q   (ctl_reg)
  );
endmodule

// File: rtl/simd_shl_ovf_chk.sv
module simd_shl_ovf_chk #(
  parameter int DATA_W = 32,
  parameter int FBIT   = 22,
  parameter int SHW    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              mode,
  input logic [DATA_W-1:0] operand,
  input logic [SHW-1:0]    shamt,
  input logic              ctl_wr_en,
  input logic [DATA_W-1:0] ctl_wr_data,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] ctl_reg
);
  logic zero_sh;
  assign zero_sh = mode ? (shamt[2:0] == 3'd0) : (shamt == '0);

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ctl_reg[FBIT] && !ctl_wr_en) |=> ctl_reg[FBIT]); // R8

  AST_OTHER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((ctl_reg & ~(DATA_W'(1) << FBIT)) == '0)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R7

  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !ctl_reg[FBIT]) |=> !ctl_reg[FBIT]); // R7

  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && zero_sh) |=> (result == $past(operand))); // R5

  AST_ZERO_SHIFT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && zero_sh && !ctl_wr_en) |=> $stable(ctl_reg)); // R5

  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_en && !ctl_wr_data[FBIT] && !in_valid) |=> !ctl_reg[FBIT]); // R9
endmodule

bind simd_shl_ovf simd_shl_ovf_chk #(.DATA_W(DATA_W), .FBIT(FBIT), .SHW(SHW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .mode        (mode),
  .operand     (operand),
  .shamt       (shamt),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_wr_data (ctl_wr_data),
  .result      (result),
  .ctl_reg     (ctl_reg)
);

// File: tb/simd_shl_ovf_tb_top.sv
module simd_shl_ovf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        mode;
  logic [31:0] operand;
  logic [3:0]  shamt;
  logic        ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic [31:0] result;
  logic [31:0] ctl_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_shl_ovf dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .operand(operand), .shamt(shamt), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_data(ctl_wr_data), .result(result), .ctl_reg(ctl_reg)
  );

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // one operation: drive at negedge, sample after the next posedge
  task automatic run_op(logic m, logic [31:0] op, logic [3:0] sh);
    in_valid = 1'b1; mode = m; operand = op; shamt = sh;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_flag();
    ctl_wr_en = 1'b1; ctl_wr_data = 32'h0;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check32("R11", "result after reset", result, 32'h0);
    check32("R11", "ctl_reg after reset", ctl_reg, 32'h0);
  endtask

  task automatic t_byte();
    clear_flag();
    run_op(1'b1, 32'h87654321, 4'd3);
    check32("R1", "byte 0x87654321<<3", result, 32'h38281808);
    check32("R2", "byte overflow set", ctl_reg, 32'h0040_0000);
    clear_flag();
    run_op(1'b1, 32'h00000001, 4'd7);
    check32("R1", "byte 0x1<<7", result, 32'h00000080);
    check32("R2", "byte no overflow", ctl_reg, 32'h0);
  endtask

  task automatic t_half();
    clear_flag();
    run_op(1'b0, 32'h7FFF8000, 4'd1);
    check32("R3", "half 0x7FFF8000<<1", result, 32'hFFFE0000);
    check32("R4", "half overflow both lanes", ctl_reg, 32'h0040_0000);
    clear_flag();
    run_op(1'b0, 32'h00000001, 4'd15);
    check32("R3", "half 0x1<<15", result, 32'h00008000);
    check32("R4", "half sign change overflow", ctl_reg, 32'h0040_0000);
    clear_flag();
    run_op(1'b0, 32'hFFC0FFFF, 4'd4);
    check32("R3", "half negative stays negative", result, 32'hFC00FFF0);
    check32("R4", "half negative no overflow", ctl_reg, 32'h0);
  endtask

  task automatic t_zero();
    clear_flag();
    run_op(1'b1, 32'hFFFFFFFF, 4'd0);
    check32("R5", "byte shift 0 result", result, 32'hFFFFFFFF);
    check32("R5", "byte shift 0 flag", ctl_reg, 32'h0);
    run_op(1'b0, 32'h8000FFFF, 4'd0);
    check32("R5", "half shift 0 result", result, 32'h8000FFFF);
    check32("R5", "half shift 0 flag", ctl_reg, 32'h0);
  endtask

  task automatic t_upper_ignored();
    clear_flag();
    run_op(1'b1, 32'h01020304, 4'b1011);
    check32("R6", "byte shamt bit3 ignored result", result, 32'h08101820);
    check32("R6", "byte shamt bit3 ignored flag", ctl_reg, 32'h0);
  endtask

  task automatic t_hold();
    clear_flag();
    run_op(1'b1, 32'h11223344, 4'd1);
    check32("R7", "registered result", result, 32'h22446688);
    in_valid = 1'b0; mode = 1'b1; operand = 32'hFFFFFFFF; shamt = 4'd7;
    @(negedge clk);
    check32("R7", "result held without valid", result, 32'h22446688);
    check32("R7", "flag not set without valid", ctl_reg, 32'h0);
  endtask

  task automatic t_sticky_clear();
    clear_flag();
    run_op(1'b1, 32'h80000000, 4'd1);
    run_op(1'b1, 32'h00000001, 4'd1);
    check32("R8", "flag sticky after clean op", ctl_reg, 32'h0040_0000);
    ctl_wr_en = 1'b1; ctl_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    check32("R9", "write 1 keeps flag", ctl_reg, 32'h0040_0000);
    clear_flag();
    check32("R9", "write 0 clears flag", ctl_reg, 32'h0);
    ctl_wr_en = 1'b1; ctl_wr_data = 32'h0040_0000;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    check32("R9", "write 1 does not set", ctl_reg, 32'h0);
  endtask

  task automatic t_priority();
    clear_flag();
    run_op(1'b1, 32'h80000000, 4'd1);
    ctl_wr_en = 1'b1; ctl_wr_data = 32'h0;
    run_op(1'b0, 32'h40000000, 4'd2);
    ctl_wr_en = 1'b0;
    check32("R10", "overflow beats clear", ctl_reg, 32'h0040_0000);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; mode = 1'b0; operand = '0; shamt = '0;
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_byte();
    t_half();
    t_zero();
    t_upper_ignored();
    t_hold();
    t_sticky_clear();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule